// File: doc/BRIEF.md
# Two's-Complement Array Multiplier

This block multiplies two signed operands of `WIDTH` bits each and returns the full signed product of `2*WIDTH` bits. It is purely combinational and has no clock or reset, so the product follows the operands within the same cycle. It is meant to sit inside a larger datapath, for example the multiply stage of a filter tap, where a registered stage around it sets the timing.

Internally the block is a regular grid of `WIDTH` rows of one-bit adder cells. Row j adds the partial product `op_a & op_b[j]` to a running sum. That running sum leaves the row with its lowest bit retired as a product bit and the rest shifted down one place. Every bit in the grid has a fixed weight sign.

- Bits with an ordinary, positive weight go through plain full adders.
- Bits of negative weight go through a signed-digit cell. It obeys x + y − z = 2c − s and is used in its mirrored reading −x − y + z = −2c + s. Both readings share one truth table.
- A partial-product bit with exactly one sign-bit factor has negative weight. The sign-by-sign bit has positive weight.
- The final row is built only from signed-digit cells. It acts as the vector-merging row and hands out the upper product bits, already in two's-complement form.

No sign extension and no correction term are needed.

Top module: `tc_array_mult`

## Requirements
- R1: For every pair of signed operands, `prod` equals the two's-complement product op_a × op_b. Bit 2*WIDTH−1 of `prod` is the sign.
- R2: The most negative value times itself (−2^(WIDTH−1) squared) gives the positive product 2^(2*WIDTH−2) with the sign bit clear.
- R3: A full-adder cell with inputs x, y, ci gives outputs that satisfy x + y + ci = 2·co + s, for all eight input patterns.
- R4: A signed-digit cell maps inputs (x,y,z) to outputs (c,s) as follows: 000→00, 001→01, 010→11, 011→00, 100→11, 101→00, 110→10, 111→11. This gives x + y − z = 2c − s.
- R5: The block is combinational: a new operand pair shows its product on `prod` without any clock edge.
- R6: A zero in either operand gives an all-zero product.
- R7: Multiplying by −1 (all ones in `op_b`) gives the two's-complement negation of `op_a`, extended to 2*WIDTH bits.
- R8: Each array row keeps its signed value: the weighted sum of its outputs equals the weighted sum of its inputs. The weights are the sign of each bit position for that row kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Signed multiplicand, two's complement |
| op_b | input | WIDTH | Signed multiplier, two's complement; bit j selects row j |
| prod | output | 2*WIDTH | Signed product, two's complement |

## Verification
The bench builds the multiplier twice: once with WIDTH = 4 and once with WIDTH = 8. Both widths are swept over every operand pair, which is 256 pairs at four bits and 65,536 pairs at eight bits. The sweeps reach every sign combination, the most-negative-squared case, the zero rows and the multiply-by-minus-one case at both widths. The two cell kinds are also instantiated on their own and driven through all eight input patterns. That pins their truth tables independently of the array built from them.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    // Row flavour inside the array: body rows carry a negative-weight MSB,
    // the closing row carries negative-weight partial products in its low bits.
    typedef enum logic [0:0] {
        ROW_BODY  = 1'b0,
        ROW_CLOSE = 1'b1
    } row_kind_e;

    // Signed-digit cell: x + y - z = 2c - s  (mirrored: -x - y + z = -2c + s)
    // Returns {c, s}.
    function automatic logic [1:0] sd_cell(input logic x, input logic y, input logic z);
        logic s;
        logic c;
        s = x ^ y ^ z;
        c = ((x | y) & ~z) | (x & y);
        return {c, s};
    endfunction

endpackage

// File: rtl/tcam_cell_fa.sv
module tcam_cell_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end

    // R3: arithmetic identity of the positive-weight cell
    always_comb begin
        if (!$isunknown({x, y, ci, s, co})) begin
            assert_fa_sum_R3: assert ((int'(x) + int'(y) + int'(ci)) == (2 * int'(co) + int'(s)))
                else $error("full adder identity broken");
        end
    end

endmodule

// File: rtl/tcam_cell_sd.sv
module tcam_cell_sd (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    import tcam_pkg::*;

    logic [1:0] cs;

    always_comb begin
        cs = sd_cell(x, y, z);
        c  = cs[1];
        s  = cs[0];
    end

    // R4: x + y - z = 2c - s for every input pattern
    always_comb begin
        if (!$isunknown({x, y, z, s, c})) begin
            assert_sd_identity_R4: assert ((int'(x) + int'(y) - int'(z)) == (2 * int'(c) - int'(s)))
                else $error("signed-digit cell identity broken");
        end
    end

endmodule

// File: rtl/tcam_row.sv
module tcam_row #(
    parameter int                  WIDTH = 4,
    parameter tcam_pkg::row_kind_e KIND  = tcam_pkg::ROW_BODY
) (
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] pp,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_top
);
    import tcam_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] cy;

    assign cy[0]     = 1'b0;
    assign carry_top = cy[WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_col
        if (KIND == ROW_BODY && i < MSB) begin : g_pos
            // all three inputs positive
            tcam_cell_fa u_fa (
                .x  (acc_in[i]),
                .y  (pp[i]),
                .ci (cy[i]),
                .s  (sum_out[i]),
                .co (cy[i+1])
            );
        end else if (KIND == ROW_BODY) begin : g_top
            // acc MSB and pp MSB negative, carry-in positive:
            // sum leaves positive, carry leaves negative
            tcam_cell_sd u_sd (
                .x (acc_in[i]),
                .y (pp[i]),
                .z (cy[i]),
                .s (sum_out[i]),
                .c (cy[i+1])
            );
        end else if (i < MSB) begin : g_cls_lo
            // pp negative, incoming carry negative, acc bit positive
            tcam_cell_sd u_sd (
                .x (pp[i]),
                .y (cy[i]),
                .z (acc_in[i]),
                .s (sum_out[i]),
                .c (cy[i+1])
            );
        end else begin : g_cls_hi
            // acc MSB negative, carry negative, sign-by-sign pp positive
            tcam_cell_sd u_sd (
                .x (acc_in[i]),
                .y (cy[i]),
                .z (pp[i]),
                .s (sum_out[i]),
                .c (cy[i+1])
            );
        end
    end

    // R8: signed value is preserved across the row
    longint val_in;
    longint val_out;

    always_comb begin
        val_in  = 0;
        val_out = 0;
        for (int i = 0; i < WIDTH; i++) begin
            if (i == MSB) val_in = val_in - (longint'(acc_in[i]) << i);
            else          val_in = val_in + (longint'(acc_in[i]) << i);
            if ((KIND == ROW_BODY) == (i == MSB))
                val_in = val_in - (longint'(pp[i]) << i);
            else
                val_in = val_in + (longint'(pp[i]) << i);
            val_out = val_out + (longint'(sum_out[i]) << i);
        end
        val_out = val_out - (longint'(carry_top) << WIDTH);
    end

    always_comb begin
        if (!$isunknown({acc_in, pp, sum_out, carry_top})) begin
            assert_row_value_R8: assert (val_in == val_out)
                else $error("row value not preserved");
        end
    end

endmodule

// File: rtl/tc_array_mult.sv
module tc_array_mult #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod
);
    import tcam_pkg::*;

    localparam int PW   = 2 * WIDTH;
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0][WIDTH-1:0] acc;
    logic [WIDTH-1:0][WIDTH-1:0] pp;
    logic [WIDTH-1:0][WIDTH-1:0] row_sum;
    logic [WIDTH-1:0]            row_cy;

    assign acc[0] = '0;

    for (genvar j = 0; j < WIDTH; j++) begin : g_row
        assign pp[j] = op_a & {WIDTH{op_b[j]}};

        if (j < LAST) begin : g_body
            tcam_row #(.WIDTH(WIDTH), .KIND(ROW_BODY)) u_row (
                .acc_in    (acc[j]),
                .pp        (pp[j]),
                .sum_out   (row_sum[j]),
                .carry_top (row_cy[j])
            );
            // retire bit j, shift the rest down; carry becomes negative MSB
            assign prod[j]  = row_sum[j][0];
            assign acc[j+1] = {row_cy[j], row_sum[j][WIDTH-1:1]};
        end else begin : g_close
            tcam_row #(.WIDTH(WIDTH), .KIND(ROW_CLOSE)) u_row (
                .acc_in    (acc[j]),
                .pp        (pp[j]),
                .sum_out   (row_sum[j]),
                .carry_top (row_cy[j])
            );
            assign prod[PW-1:LAST] = {row_cy[j], row_sum[j]};
        end
    end

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (!$isunknown({op_a, op_b, prod})) begin
            assert_signed_product_R1: assert ($signed(prod) == ($signed(op_a) * $signed(op_b)))
                else $error("product mismatch");
            if (op_a == MOST_NEG && op_b == MOST_NEG) begin
                assert_no_overflow_R2: assert (prod[PW-1] == 1'b0)
                    else $error("most-negative square overflowed");
            end
            if (op_a == '0 || op_b == '0) begin
                assert_zero_operand_R6: assert (prod == '0)
                    else $error("zero operand gave nonzero product");
            end
        end
    end

endmodule

// File: tb/tc_array_mult_tb_top.sv
module tc_array_mult_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W4 = 4;
    localparam int W8 = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W4-1:0]   a4, b4;
    logic [2*W4-1:0] p4;
    logic [W8-1:0]   a8, b8;
    logic [2*W8-1:0] p8;

    logic fx, fy, fci, fs, fco;
    logic sx, sy, sz, ss, sc;

    tc_array_mult #(.WIDTH(W4)) dut_i (.op_a(a4), .op_b(b4), .prod(p4));
    tc_array_mult #(.WIDTH(W8)) dut8_i (.op_a(a8), .op_b(b8), .prod(p8));

    tcam_cell_fa cell_fa_i (.x(fx), .y(fy), .ci(fci), .s(fs), .co(fco));
    tcam_cell_sd cell_sd_i (.x(sx), .y(sy), .z(sz), .s(ss), .c(sc));

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_for(input longint a, input longint b, input int w);
        longint mn;
        mn = -(longint'(1) << (w - 1));
        if (a == 0 || b == 0) return "R6";
        if (a == mn && b == mn) return "R2";
        if (b == -1) return "R7";
        return "R1";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        a4 = '0; b4 = '0; a8 = '0; b8 = '0;
        fx = 0; fy = 0; fci = 0; sx = 0; sy = 0; sz = 0;
        @(negedge clk);

        // R6 at start: zero operands
        check("R6", longint'(p4), 0);

        // R3: full-adder cell, all patterns
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {fx, fy, fci} = 3'(v);
            #1;
            check("R3", 2 * longint'(fco) + longint'(fs),
                  longint'(fx) + longint'(fy) + longint'(fci));
        end

        // R4: signed-digit cell truth table from x + y - z
        for (int v = 0; v < 8; v++) begin
            longint d, es, ec;
            @(negedge clk);
            {sx, sy, sz} = 3'(v);
            d  = longint'(v[2]) + longint'(v[1]) - longint'(v[0]);
            es = (d < 0) ? 1 : (d % 2);
            ec = (d + es) / 2;
            #1;
            check("R4", {ec[0], es[0]} == {sc, ss} ? 1 : 0, 1);
        end

        // R5: product settles without a clock edge
        @(negedge clk);
        a4 = 4'sd3; b4 = -4'sd5;
        #1;
        check("R5", longint'($signed(p4)), -15);
        a4 = -4'sd7;
        #1;
        check("R5", longint'($signed(p4)), 35);

        // R1/R2/R6/R7: exhaustive sweep, WIDTH 4
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                longint sa, sb;
                @(negedge clk);
                a4 = 4'(ia); b4 = 4'(ib);
                sa = longint'($signed(a4)); sb = longint'($signed(b4));
                @(posedge clk); #1;
                check(tag_for(sa, sb, W4), longint'($signed(p4)), sa * sb);
            end
        end

        // R1/R2/R6/R7: exhaustive sweep, WIDTH 8 (R8 held by row assertions)
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                longint sa, sb;
                @(negedge clk);
                a8 = 8'(ia); b8 = 8'(ib);
                sa = longint'($signed(a8)); sb = longint'($signed(b8));
                #1;
                check(tag_for(sa, sb, W8), longint'($signed(p8)), sa * sb);
            end
        end

        // R2 explicit: sign bit clear on most-negative square
        @(negedge clk);
        a8 = 8'h80; b8 = 8'h80;
        #1;
        check("R2", longint'(p8), 64'd16384);
        check("R2", longint'(p8[2*W8-1]), 0);

        // R7 explicit: negation with full-width extension
        a8 = 8'h01; b8 = 8'hFF;
        #1;
        check("R7", longint'(p8), 64'hFFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule